// File: doc/BRIEF.md
# Shifter Operand Unit with Carry-Out

This block forms the second operand of a data-processing operation from a source value and a shift description. It also produces the carry that the shift would leave behind. The block takes a 32-bit value, one of four shift kinds, a shift amount, a bit that selects the amount's origin, and the current carry flag. It returns the shifted value and a carry-out bit. It is purely combinational. Results follow the inputs in the same cycle, with no handshake and no register.

The two amount origins treat the edge amounts differently. In immediate form the amount is a 5-bit field, and a zero encodes a special operation for three of the four kinds: a full-width right shift, or a rotate through carry. In register form the amount is the low byte of a register, 0 to 255. A zero there leaves the value and the carry untouched. Amounts of the full width or more saturate under rules that depend on the shift kind. The surrounding datapath feeds the result to the ALU and uses the carry-out as the carry flag for logical operations that set flags.

Top module: `shift_operand_unit`

## Requirements
- R1: The shift kind `kind_i` is encoded as 0 = shift left, 1 = logical shift right, 2 = arithmetic shift right, 3 = rotate right. When `reg_mode_i` is 0, only `amount_i[4:0]` is used and `amount_i[7:5]` has no effect.
- R2: Immediate form, shift left. For amount 0 the result equals the value and the carry-out equals `carry_i`. For amount n in 1..31 the result is the value shifted left by n, and the carry-out is value bit 32-n.
- R3: Immediate form, logical shift right. For amount 0 the result is 0 and the carry-out is value bit 31. For n in 1..31 the result is the value shifted right by n with zeros entering, and the carry-out is value bit n-1.
- R4: Immediate form, arithmetic shift right. For amount 0 every result bit equals value bit 31, and the carry-out is value bit 31. For n in 1..31 the result is the sign-extending shift by n, and the carry-out is value bit n-1.
- R5: Immediate form, rotate right. For amount 0 the result is `{carry_i, value[31:1]}` and the carry-out is value bit 0. For n in 1..31 the result is the value rotated right by n, and the carry-out is value bit n-1.
- R6: Register form with `amount_i` equal to 0, for every shift kind: the result equals the value and the carry-out equals `carry_i`.
- R7: Register form, shift left and logical shift right. For amounts 1..31 the shift is normal, and the carry-out is the last bit shifted out (bit 32-n for left, bit n-1 for right). For amount 32 the result is 0, and the carry-out is value bit 0 for left or value bit 31 for right. For amounts above 32, both the result and the carry-out are 0.
- R8: Register form, arithmetic shift right. For amounts 1..31 the shift is normal, with carry-out value bit n-1. For amounts of 32 or more every result bit equals value bit 31, and the carry-out is value bit 31.
- R9: Register form, rotate right with a nonzero amount. The rotation is by `amount_i[4:0]`. When those five bits are 0, the result equals the value and the carry-out is value bit 31. Otherwise the carry-out is value bit k-1, where k is `amount_i[4:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Value to be shifted |
| kind_i | input | 2 | Shift kind (0 left, 1 logical right, 2 arithmetic right, 3 rotate right) |
| amount_i | input | 8 | Shift amount; only bits 4:0 are used in immediate form |
| reg_mode_i | input | 1 | 0 = immediate-form amount, 1 = register-form amount |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
In every evaluation the block both builds the shifted value and picks the carry bit from the same decoded amount. The cases that matter are those where the two paths must agree on a saturated or special amount. Examples are register-form amount 32, where the result is already all zero but the carry must still be the last bit out, and immediate rotate by zero, where `carry_i` enters the result while bit 0 leaves as the carry. The bench drives these cases directly and then sweeps every kind, every amount from 0 to 255 and both forms. It judges the result and the carry together against a reference model written from the requirements.

// File: rtl/sou_pkg.sv
package sou_pkg;

  // Shift kind as presented on kind_i
  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;

  // Normalised operation handed from the amount decoder to the datapath
  typedef enum logic [2:0] {
    OP_LEFT        = 3'd0,
    OP_RIGHT_LOG   = 3'd1,
    OP_RIGHT_ARITH = 3'd2,
    OP_ROTATE      = 3'd3,
    OP_EXTEND      = 3'd4
  } core_op_e;

endpackage

// File: rtl/sou_amount_decode.sv
// Maps (kind, amount, form) to one operation and an effective amount in 0..DATA_W.
module sou_amount_decode
  import sou_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  localparam int IMM_W = $clog2(DATA_W),
  localparam int N_W   = IMM_W + 1
) (
  input  shift_kind_e      kind,
  input  logic [AMT_W-1:0] amount,
  input  logic             reg_mode,
  output core_op_e         op,
  output logic [N_W-1:0]   eff_n,
  output logic             carry_kill
);

  localparam logic [N_W-1:0] FULL = N_W'(DATA_W);

  logic [IMM_W-1:0] low;
  logic             low_zero;
  logic             amt_zero;
  logic             at_or_above;
  logic             above;
  logic [N_W-1:0]   sat_n;

  assign low         = amount[IMM_W-1:0];
  assign low_zero    = (low == '0);
  assign amt_zero    = (amount == '0);
  assign at_or_above = (int'(amount) >= DATA_W);
  assign above       = (int'(amount) > DATA_W);
  assign sat_n       = at_or_above ? FULL : N_W'(amount);

  always_comb begin
    op         = OP_LEFT;
    eff_n      = '0;
    carry_kill = 1'b0;
    if (!reg_mode) begin
      unique case (kind)
        SK_LSL: begin
          op    = OP_LEFT;
          eff_n = {1'b0, low};
        end
        SK_LSR: begin
          op    = OP_RIGHT_LOG;
          eff_n = low_zero ? FULL : {1'b0, low};
        end
        SK_ASR: begin
          op    = OP_RIGHT_ARITH;
          eff_n = low_zero ? FULL : {1'b0, low};
        end
        default: begin
          op    = low_zero ? OP_EXTEND : OP_ROTATE;
          eff_n = {1'b0, low};
        end
      endcase
    end else if (amt_zero) begin
      op    = OP_LEFT;          // shift by zero: value and carry pass through
      eff_n = '0;
    end else begin
      unique case (kind)
        SK_LSL: begin
          op         = OP_LEFT;
          eff_n      = sat_n;
          carry_kill = above;
        end
        SK_LSR: begin
          op         = OP_RIGHT_LOG;
          eff_n      = sat_n;
          carry_kill = above;
        end
        SK_ASR: begin
          op    = OP_RIGHT_ARITH;
          eff_n = sat_n;
        end
        default: begin
          op    = OP_ROTATE;
          eff_n = low_zero ? FULL : {1'b0, low};
        end
      endcase
    end
  end

endmodule

// File: rtl/sou_linear_shift.sv
// Left and right shifts through an extended vector; the carry is the extra bit.
module sou_linear_shift
  import sou_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int N_W   = $clog2(DATA_W) + 1,
  localparam int EXT_W = 2 * DATA_W + 1
) (
  input  logic [DATA_W-1:0] value,
  input  logic              cin,
  input  core_op_e          op,
  input  logic [N_W-1:0]    n,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  logic [DATA_W-1:0] fill;
  logic [EXT_W-1:0]  left_ext;
  logic [EXT_W-1:0]  right_ext;

  assign fill      = (op == OP_RIGHT_ARITH) ? {DATA_W{value[DATA_W-1]}} : '0;
  assign left_ext  = {cin, value, {DATA_W{1'b0}}} << n;
  assign right_ext = {fill, value, cin} >> n;

  always_comb begin
    if (op == OP_LEFT) begin
      res  = left_ext[2*DATA_W-1:DATA_W];
      cout = left_ext[2*DATA_W];
    end else begin
      res  = right_ext[DATA_W:1];
      cout = right_ext[0];
    end
  end

endmodule

// File: rtl/sou_rotator.sv
// Logarithmic rotate-right; an amount of DATA_W wraps to a full turn.
module sou_rotator #(
  parameter int DATA_W = 32,
  localparam int IMM_W = $clog2(DATA_W),
  localparam int N_W   = IMM_W + 1
) (
  input  logic [DATA_W-1:0] value,
  input  logic              cin,
  input  logic [N_W-1:0]    n,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  logic [DATA_W-1:0] stage [IMM_W+1];

  assign stage[0] = value;

  for (genvar k = 0; k < IMM_W; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stage[k+1] = n[k] ? {stage[k][S-1:0], stage[k][DATA_W-1:S]} : stage[k];
  end

  assign res  = stage[IMM_W];
  assign cout = (n == '0) ? cin : stage[IMM_W][DATA_W-1];

endmodule

// File: rtl/shift_operand_unit.sv
module shift_operand_unit
  import sou_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [1:0]        kind_i,
  input  logic [AMT_W-1:0]  amount_i,
  input  logic              reg_mode_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);

  localparam int N_W = $clog2(DATA_W) + 1;

  core_op_e          op;
  logic [N_W-1:0]    eff_n;
  logic              carry_kill;
  logic [DATA_W-1:0] lin_res, rot_res, ext_res;
  logic              lin_c, rot_c;

  sou_amount_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dec (
    .kind       (shift_kind_e'(kind_i)),
    .amount     (amount_i),
    .reg_mode   (reg_mode_i),
    .op         (op),
    .eff_n      (eff_n),
    .carry_kill (carry_kill)
  );

  sou_linear_shift #(.DATA_W(DATA_W)) u_lin (
    .value (opnd_i),
    .cin   (carry_i),
    .op    (op),
    .n     (eff_n),
    .res   (lin_res),
    .cout  (lin_c)
  );

  sou_rotator #(.DATA_W(DATA_W)) u_rot (
    .value (opnd_i),
    .cin   (carry_i),
    .n     (eff_n),
    .res   (rot_res),
    .cout  (rot_c)
  );

  // Rotate by one through the carry flag
  assign ext_res = {carry_i, opnd_i[DATA_W-1:1]};

  always_comb begin
    unique case (op)
      OP_ROTATE: begin
        result_o = rot_res;
        carry_o  = rot_c;
      end
      OP_EXTEND: begin
        result_o = ext_res;
        carry_o  = opnd_i[0];
      end
      default: begin
        result_o = lin_res;
        carry_o  = lin_c & ~carry_kill;
      end
    endcase
  end

endmodule

// File: rtl/sou_checker.sv
module sou_checker #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input logic [DATA_W-1:0] opnd_i,
  input logic [1:0]        kind_i,
  input logic [AMT_W-1:0]  amount_i,
  input logic              reg_mode_i,
  input logic              carry_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o
);

  localparam int IMM_W = $clog2(DATA_W);

  always_comb begin
    // R2: immediate shift-left by zero passes value and carry
    if (!reg_mode_i && kind_i == 2'd0 && amount_i[IMM_W-1:0] == '0)
      a_r2_lsl_zero_pass: assert (result_o == opnd_i && carry_o == carry_i);
    // R5: immediate rotate by zero rotates through the carry
    if (!reg_mode_i && kind_i == 2'd3 && amount_i[IMM_W-1:0] == '0)
      a_r5_rrx: assert (result_o == {carry_i, opnd_i[DATA_W-1:1]} && carry_o == opnd_i[0]);
    // R6: register amount zero leaves value and carry untouched
    if (reg_mode_i && amount_i == '0)
      a_r6_reg_zero_keeps: assert (result_o == opnd_i && carry_o == carry_i);
    // R7: register linear shifts beyond the width clear everything
    if (reg_mode_i && kind_i[1] == 1'b0 && int'(amount_i) > DATA_W)
      a_r7_beyond_width_zero: assert (result_o == '0 && carry_o == 1'b0);
    // R4, R8: arithmetic shifts keep the sign in the top bit
    if (kind_i == 2'd2)
      a_r8_asr_sign_kept: assert (result_o[DATA_W-1] == opnd_i[DATA_W-1]);
    // R9: register rotate by a multiple of the width is a full turn
    if (reg_mode_i && kind_i == 2'd3 && amount_i != '0 && amount_i[IMM_W-1:0] == '0)
      a_r9_full_turn: assert (result_o == opnd_i && carry_o == opnd_i[DATA_W-1]);
  end

endmodule

bind shift_operand_unit sou_checker #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_sou_chk (
  .opnd_i     (opnd_i),
  .kind_i     (kind_i),
  .amount_i   (amount_i),
  .reg_mode_i (reg_mode_i),
  .carry_i    (carry_i),
  .result_o   (result_o),
  .carry_o    (carry_o)
);

// File: tb/shift_operand_unit_tb_top.sv
module shift_operand_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd_i = '0;
  logic [1:0]  kind_i = '0;
  logic [7:0]  amount_i = '0;
  logic        reg_mode_i = 1'b0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [31:0] v;
    logic [1:0]  k;
    logic [7:0]  a;
    logic        rm;
    logic        c;
    logic [31:0] exp_r;
    logic        exp_c;
    string       tag;
  } item_t;

  item_t sb_q[$];

  always #10 clk = ~clk;   // 50 MHz

  shift_operand_unit dut_i (
    .opnd_i     (opnd_i),
    .kind_i     (kind_i),
    .amount_i   (amount_i),
    .reg_mode_i (reg_mode_i),
    .carry_i    (carry_i),
    .result_o   (result_o),
    .carry_o    (carry_o)
  );

  // Reference model written from the requirements; returns {carry, result}
  function automatic logic [32:0] ref_model(logic [31:0] v, logic [1:0] k,
                                            logic [7:0] a, logic rm, logic c);
    int n;
    logic [31:0] sign;
    sign = {32{v[31]}};
    if (!rm) begin
      n = int'(a[4:0]);
      case (k)
        2'd0: return (n == 0) ? {c, v} : {v[32-n], v << n};
        2'd1: return (n == 0) ? {v[31], 32'h0} : {v[n-1], v >> n};
        2'd2: return (n == 0) ? {v[31], sign} : {v[n-1], 32'($signed(v) >>> n)};
        default: return (n == 0) ? {v[0], c, v[31:1]}
                                 : {v[n-1], (v >> n) | (v << (32 - n))};
      endcase
    end
    n = int'(a);
    if (n == 0) return {c, v};
    case (k)
      2'd0: begin
        if (n < 32) return {v[32-n], v << n};
        if (n == 32) return {v[0], 32'h0};
        return 33'h0;
      end
      2'd1: begin
        if (n < 32) return {v[n-1], v >> n};
        if (n == 32) return {v[31], 32'h0};
        return 33'h0;
      end
      2'd2: begin
        if (n < 32) return {v[n-1], 32'($signed(v) >>> n)};
        return {v[31], sign};
      end
      default: begin
        n = int'(a[4:0]);
        if (n == 0) return {v[31], v};
        return {v[n-1], (v >> n) | (v << (32 - n))};
      end
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] k, logic [7:0] a, logic rm);
    if (!rm) begin
      case (k)
        2'd0: return "R2";
        2'd1: return "R3";
        2'd2: return "R4";
        default: return "R5";
      endcase
    end
    if (a == 8'd0) return "R6";
    case (k)
      2'd0, 2'd1: return "R7";
      2'd2: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Driver: apply stimulus on the falling edge and queue the expectation
  task automatic drive(logic [31:0] v, logic [1:0] k, logic [7:0] a,
                       logic rm, logic c, string tag);
    item_t it;
    logic [32:0] e;
    @(negedge clk);
    opnd_i = v; kind_i = k; amount_i = a; reg_mode_i = rm; carry_i = c;
    e = ref_model(v, k, a, rm, c);
    it.v = v; it.k = k; it.a = a; it.rm = rm; it.c = c;
    it.exp_r = e[31:0];
    it.exp_c = e[32];
    it.tag = (tag == "") ? tag_of(k, a, rm) : tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compare on the rising edge, half a period after the drive
  always @(posedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_tests++;
      if (result_o !== it.exp_r || carry_o !== it.exp_c) begin
        n_fail++;
        $display("FAIL %s: kind=%0d amt=%0d reg=%0b val=%h cin=%0b got res=%h c=%b expected res=%h c=%b",
                 it.tag, it.k, it.a, it.rm, it.v, it.c, result_o, carry_o, it.exp_r, it.exp_c);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle state after reset: all-zero inputs give zero outputs (R2)
    drive(32'h0, 2'd0, 8'd0, 1'b0, 1'b0, "R2");
    // R1: upper amount bits ignored in immediate form
    drive(32'h8000_00F0, 2'd1, 8'hE0, 1'b0, 1'b0, "R1");
    drive(32'h8000_00F0, 2'd1, 8'h23, 1'b0, 1'b1, "R1");
    drive(32'h1234_5678, 2'd3, 8'hA0, 1'b0, 1'b1, "R1");
    // R2
    drive(32'hDEAD_BEEF, 2'd0, 8'd0, 1'b0, 1'b1, "R2");
    drive(32'h8000_0001, 2'd0, 8'd1, 1'b0, 1'b0, "R2");
    drive(32'h0000_0003, 2'd0, 8'd31, 1'b0, 1'b0, "R2");
    // R3
    drive(32'h8000_0000, 2'd1, 8'd0, 1'b0, 1'b0, "R3");
    drive(32'h0000_0003, 2'd1, 8'd1, 1'b0, 1'b0, "R3");
    drive(32'hC000_0000, 2'd1, 8'd31, 1'b0, 1'b1, "R3");
    // R4
    drive(32'h8000_1234, 2'd2, 8'd0, 1'b0, 1'b0, "R4");
    drive(32'h7FFF_1234, 2'd2, 8'd0, 1'b0, 1'b1, "R4");
    drive(32'hF000_0010, 2'd2, 8'd5, 1'b0, 1'b0, "R4");
    // R5
    drive(32'h0000_0001, 2'd3, 8'd0, 1'b0, 1'b1, "R5");
    drive(32'hFFFF_FFFE, 2'd3, 8'd0, 1'b0, 1'b0, "R5");
    drive(32'h0000_000F, 2'd3, 8'd4, 1'b0, 1'b0, "R5");
    // R6
    for (int k = 0; k < 4; k++)
      drive(32'hA5A5_0F0F, 2'(k), 8'd0, 1'b1, 1'b1, "R6");
    // R7
    drive(32'h0000_0001, 2'd0, 8'd32, 1'b1, 1'b0, "R7");
    drive(32'hFFFF_FFFF, 2'd0, 8'd33, 1'b1, 1'b1, "R7");
    drive(32'hFFFF_FFFF, 2'd0, 8'd255, 1'b1, 1'b1, "R7");
    drive(32'h0000_0002, 2'd0, 8'd31, 1'b1, 1'b0, "R7");
    drive(32'h8000_0000, 2'd1, 8'd32, 1'b1, 1'b0, "R7");
    drive(32'hFFFF_FFFF, 2'd1, 8'd40, 1'b1, 1'b1, "R7");
    // R8
    drive(32'h8000_0000, 2'd2, 8'd32, 1'b1, 1'b0, "R8");
    drive(32'h8765_4321, 2'd2, 8'd200, 1'b1, 1'b0, "R8");
    drive(32'h7FFF_FFFF, 2'd2, 8'd100, 1'b1, 1'b1, "R8");
    // R9
    drive(32'h8000_0001, 2'd3, 8'd32, 1'b1, 1'b0, "R9");
    drive(32'h0000_0001, 2'd3, 8'd64, 1'b1, 1'b1, "R9");
    drive(32'h0000_0002, 2'd3, 8'd33, 1'b1, 1'b0, "R9");
    drive(32'h8000_0000, 2'd3, 8'd255, 1'b1, 1'b0, "R9");
    // Sweep of every kind, form and amount
    for (int rm = 0; rm < 2; rm++)
      for (int k = 0; k < 4; k++)
        for (int a = 0; a < 256; a++)
          drive($urandom, 2'(k), 8'(a), 1'(rm), 1'(a ^ k), "");
    // Random mix, both carry values
    for (int i = 0; i < 1000; i++)
      drive($urandom, 2'($urandom), 8'($urandom), 1'($urandom), 1'(i), "");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule